// File: doc/BRIEF.md
# Pointer-Based Hard-Fault Repair for a Memory Line

This block sits between a wear-prone non-volatile array and its consumer, on the path of one 512-bit line. It keeps a short table of repair entries. Each entry records the bit position of a cell that has failed for good, together with the value that cell ought to hold. When the line is read, the raw word from the array passes through the table. Every recorded position is overwritten with its stored value, and the corrected word comes out one clock later.

When the line is written, the stored value of every live entry is reloaded from the new data, so the repaired cells always follow the most recent write. A verify step outside the block may find a newly stuck cell. It then reports the position and the intended value, and the block claims the next free entry for it. A failing entry can be repaired by a later entry for the same position, because the entries are applied in index order and the higher index is applied last. Once the table is full, any further report marks the line as beyond repair and leaves the table untouched.

Top module: `ecp_line_repair`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, no entry is in use: the count is 0, the beyond-repair and in-use flags are low, and the read-valid output is low.
- R2: A read request asserts read-valid exactly one clock later. With no entries in use, the read data equals the raw word that was sampled with the request.
- R3: On a read, each bit position named by an entry in use is replaced by that entry's stored value. All other bits pass through unchanged. The result appears one clock after the request.
- R4: If two entries in use name the same position, the entry with the higher index decides the value of that bit.
- R5: A write loads, for every entry already in use, its stored value from the written word at that entry's position. Reads that follow use the new values.
- R6: A fault report with fewer than 6 entries in use fills the lowest free index with the reported position (0 is the least significant bit) and the reported value, and the count rises by one on the next clock.
- R7: If a write and a fault report arrive in the same cycle, the new entry takes its value from the written word at the reported position, and the reported value is ignored.
- R8: A fault report with all 6 entries in use sets a sticky beyond-repair flag. The count and the contents of every entry stay unchanged.
- R9: The in-use flag is high exactly when at least one entry is in use.
- R10: A read issued in the same cycle as a write or a fault report is corrected with the table as it stood before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request; the raw word is sampled with it |
| rd_raw_i | input | 512 | Raw word from the array |
| rd_valid_o | output | 1 | Corrected word valid |
| rd_data_o | output | 512 | Corrected word |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 512 | Word being written to the line |
| flt_en_i | input | 1 | Report of a newly found stuck cell |
| flt_pos_i | input | 9 | Bit position of the stuck cell |
| flt_val_i | input | 1 | Value the stuck cell should hold |
| unrep_o | output | 1 | Sticky: a report arrived with the table full |
| active_o | output | 1 | At least one entry is in use |
| used_cnt_o | output | 3 | Number of entries in use |

## Verification
Three updates can land in one cycle: a write refreshing the stored values, a fault report claiming an entry, and a read passing through the table. The bench drives a write and a report together, with the reported value set opposite to the written bit. A later read over an all-zero raw word then shows which of the two sources the new entry took. Reads issued alongside writes are compared against the table contents from before the cycle. A full 512-position sweep and a duplicate-position case cover the overwrite order.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
    localparam int unsigned ECP_LINE_W = 512;
    localparam int unsigned ECP_N_ENT  = 6;

    typedef enum logic [1:0] {
        ALLOC_NONE   = 2'd0,
        ALLOC_NEW    = 2'd1,
        ALLOC_REFUSE = 2'd2
    } alloc_e;
endpackage

// File: rtl/ecp_alloc.sv
module ecp_alloc
    import ecp_pkg::*;
#(
    parameter int unsigned N_ENT = ECP_N_ENT,
    localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
    input  logic             flt_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output alloc_e           outcome_o,
    output logic [N_ENT-1:0] slot_oh_o
);
    logic full;

    assign full = (cnt_i >= CNT_W'(N_ENT));

    always_comb begin
        if (!flt_en_i) begin
            outcome_o = ALLOC_NONE;
        end else if (full) begin
            outcome_o = ALLOC_REFUSE;
        end else begin
            outcome_o = ALLOC_NEW;
        end
    end

    // Lowest free index equals the current count, since entries fill in order.
    always_comb begin
        for (int i = 0; i < int'(N_ENT); i++) begin
            slot_oh_o[i] = (outcome_o == ALLOC_NEW) && (cnt_i == CNT_W'(i));
        end
    end
endmodule

// File: rtl/ecp_patch.sv
module ecp_patch #(
    parameter int unsigned LINE_W = 512,
    parameter int unsigned N_ENT  = 6,
    localparam int unsigned POS_W = $clog2(LINE_W)
) (
    input  logic [LINE_W-1:0]           raw_i,
    input  logic [N_ENT-1:0]            vld_i,
    input  logic [N_ENT-1:0][POS_W-1:0] pos_i,
    input  logic [N_ENT-1:0]            val_i,
    output logic [LINE_W-1:0]           fixed_o
);
    logic [LINE_W-1:0] stage [0:N_ENT];

    assign stage[0] = raw_i;

    // One overwrite stage per entry; later stages win on equal positions.
    for (genvar g = 0; g < int'(N_ENT); g++) begin : g_stage
        logic [LINE_W-1:0] sel;
        logic [LINE_W-1:0] ins;
        assign sel = LINE_W'(1) << pos_i[g];
        assign ins = val_i[g] ? sel : '0;
        assign stage[g+1] = vld_i[g] ? ((stage[g] & ~sel) | ins) : stage[g];
    end

    assign fixed_o = stage[N_ENT];
endmodule

// File: rtl/ecp_table.sv
module ecp_table
    import ecp_pkg::*;
#(
    parameter int unsigned LINE_W = 512,
    parameter int unsigned N_ENT  = 6,
    localparam int unsigned POS_W = $clog2(LINE_W),
    localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [LINE_W-1:0]           wr_data_i,
    input  alloc_e                      outcome_i,
    input  logic [N_ENT-1:0]            slot_oh_i,
    input  logic [POS_W-1:0]            flt_pos_i,
    input  logic                        flt_val_i,
    output logic [N_ENT-1:0]            vld_o,
    output logic [N_ENT-1:0][POS_W-1:0] pos_o,
    output logic [N_ENT-1:0]            val_o,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        unrep_o
);
    typedef struct packed {
        logic [N_ENT-1:0]            vld;
        logic [N_ENT-1:0][POS_W-1:0] pos;
        logic [N_ENT-1:0]            val;
        logic [CNT_W-1:0]            cnt;
        logic                        unrep;
    } tbl_t;

    tbl_t st_d, st_q;
    logic new_val;

    assign new_val = wr_en_i ? wr_data_i[flt_pos_i] : flt_val_i;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 0; i < int'(N_ENT); i++) begin
                if (st_q.vld[i]) begin
                    st_d.val[i] = wr_data_i[st_q.pos[i]];
                end
            end
        end
        case (outcome_i)
            ALLOC_NEW: begin
                for (int i = 0; i < int'(N_ENT); i++) begin
                    if (slot_oh_i[i]) begin
                        st_d.vld[i] = 1'b1;
                        st_d.pos[i] = flt_pos_i;
                        st_d.val[i] = new_val;
                    end
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            ALLOC_REFUSE: st_d.unrep = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o   = st_q.vld;
    assign pos_o   = st_q.pos;
    assign val_o   = st_q.val;
    assign cnt_o   = st_q.cnt;
    assign unrep_o = st_q.unrep;
endmodule

// File: rtl/ecp_line_repair.sv
module ecp_line_repair
    import ecp_pkg::*;
#(
    parameter int unsigned LINE_W = ECP_LINE_W,
    parameter int unsigned N_ENT  = ECP_N_ENT,
    localparam int unsigned POS_W = $clog2(LINE_W),
    localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [LINE_W-1:0] rd_raw_i,
    output logic              rd_valid_o,
    output logic [LINE_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic              flt_en_i,
    input  logic [POS_W-1:0]  flt_pos_i,
    input  logic              flt_val_i,
    output logic              unrep_o,
    output logic              active_o,
    output logic [CNT_W-1:0]  used_cnt_o
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] data;
    } rd_t;

    alloc_e                      outcome;
    logic [N_ENT-1:0]            slot_oh;
    logic [N_ENT-1:0]            ent_vld;
    logic [N_ENT-1:0][POS_W-1:0] ent_pos;
    logic [N_ENT-1:0]            ent_val;
    logic [CNT_W-1:0]            cnt;
    logic [LINE_W-1:0]           fixed;
    rd_t                         rd_d, rd_q;

    ecp_alloc #(.N_ENT(N_ENT)) i_alloc (
        .flt_en_i  (flt_en_i),
        .cnt_i     (cnt),
        .outcome_o (outcome),
        .slot_oh_o (slot_oh)
    );

    ecp_table #(.LINE_W(LINE_W), .N_ENT(N_ENT)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .outcome_i (outcome),
        .slot_oh_i (slot_oh),
        .flt_pos_i (flt_pos_i),
        .flt_val_i (flt_val_i),
        .vld_o     (ent_vld),
        .pos_o     (ent_pos),
        .val_o     (ent_val),
        .cnt_o     (cnt),
        .unrep_o   (unrep_o)
    );

    ecp_patch #(.LINE_W(LINE_W), .N_ENT(N_ENT)) i_patch (
        .raw_i   (rd_raw_i),
        .vld_i   (ent_vld),
        .pos_i   (ent_pos),
        .val_i   (ent_val),
        .fixed_o (fixed)
    );

    always_comb begin
        rd_d      = rd_q;
        rd_d.vld  = rd_en_i;
        if (rd_en_i) begin
            rd_d.data = fixed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.vld;
    assign rd_data_o  = rd_q.data;
    assign active_o   = |ent_vld;
    assign used_cnt_o = cnt;
endmodule

// File: rtl/ecp_line_repair_chk.sv
module ecp_line_repair_chk #(
    parameter int unsigned LINE_W = 512,
    parameter int unsigned N_ENT  = 6,
    localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic [LINE_W-1:0] rd_raw_i,
    input logic              rd_valid_o,
    input logic [LINE_W-1:0] rd_data_o,
    input logic              flt_en_i,
    input logic              unrep_o,
    input logic              active_o,
    input logic [CNT_W-1:0]  used_cnt_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (used_cnt_o == '0 && !unrep_o && !rd_valid_o));

    p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    p_empty_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && used_cnt_o == '0) |=> rd_data_o == $past(rd_raw_i));

    p_alloc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en_i && used_cnt_o < CNT_W'(N_ENT)) |=> used_cnt_o == $past(used_cnt_o) + 1'b1);

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en_i |=> $stable(used_cnt_o));

    p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en_i && used_cnt_o == CNT_W'(N_ENT)) |=> (unrep_o && used_cnt_o == CNT_W'(N_ENT)));

    p_unrep_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unrep_o |=> unrep_o);

    p_active_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active_o == (used_cnt_o != '0));
endmodule

bind ecp_line_repair ecp_line_repair_chk #(.LINE_W(LINE_W), .N_ENT(N_ENT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .rd_raw_i   (rd_raw_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .flt_en_i   (flt_en_i),
    .unrep_o    (unrep_o),
    .active_o   (active_o),
    .used_cnt_o (used_cnt_o)
);

// File: tb/test_ecp_line_repair.sv
`timescale 1ns/1ps
module test_ecp_line_repair;
    localparam int W = 512;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_raw = '0;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         flt_en = 1'b0;
    logic [8:0]   flt_pos = '0;
    logic         flt_val = 1'b0;
    logic         unrep, active;
    logic [2:0]   used_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    int   m_pos [N];
    logic m_val [N];
    int   m_cnt;
    logic m_unrep;

    always #10 clk = ~clk;

    ecp_line_repair i_ecp_line_repair (
        .clk(clk), .rst_n(rst_n),
        .rd_en_i(rd_en), .rd_raw_i(rd_raw), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .flt_en_i(flt_en), .flt_pos_i(flt_pos), .flt_val_i(flt_val),
        .unrep_o(unrep), .active_o(active), .used_cnt_o(used_cnt)
    );

    function automatic logic [W-1:0] rnd_line();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [W-1:0] model_fix(input logic [W-1:0] raw);
        logic [W-1:0] v = raw;
        for (int k = 0; k < m_cnt; k++) v[m_pos[k]] = m_val[k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_cnt = 0;
        m_unrep = 1'b0;
        @(negedge clk);
        // R1: state while reset is held
        chk("R1", W'(used_cnt), W'(0));
        chk("R1", W'({unrep, active, rd_valid}), W'(0));
        rst_n = 1'b1;
    endtask

    // One clock: drive after a falling edge, update the model at the rising
    // edge, compare after the next falling edge.
    task automatic step(input logic rd, input logic [W-1:0] raw,
                        input logic wr, input logic [W-1:0] wd,
                        input logic fe, input int fp, input logic fv,
                        input string rtag);
        logic [W-1:0] exp_rd;
        exp_rd = model_fix(raw);   // R10: table as it stood before this cycle
        rd_en = rd; rd_raw = raw; wr_en = wr; wr_data = wd;
        flt_en = fe; flt_pos = 9'(fp); flt_val = fv;
        @(posedge clk);
        if (wr) for (int k = 0; k < m_cnt; k++) m_val[k] = wd[m_pos[k]];
        if (fe) begin
            if (m_cnt == N) m_unrep = 1'b1;
            else begin
                m_pos[m_cnt] = fp;
                m_val[m_cnt] = wr ? wd[fp] : fv;
                m_cnt++;
            end
        end
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; flt_en = 1'b0;
        chk("R2", W'(rd_valid), W'(rd));
        if (rd) chk(rtag, rd_data, exp_rd);
        chk("R6", W'(used_cnt), W'(m_cnt));
        chk("R8", W'(unrep), W'(m_unrep));
        chk("R9", W'(active), W'(m_cnt != 0));
    endtask

    task automatic rd_only(input logic [W-1:0] raw, input string rtag);
        step(1'b1, raw, 1'b0, '0, 1'b0, 0, 1'b0, rtag);
    endtask

    task automatic fault(input int fp, input logic fv);
        step(1'b0, '0, 1'b0, '0, 1'b1, fp, fv, "R6");
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        m_cnt = 0;
        m_unrep = 1'b0;
        do_reset();
        // R1: first cycle after release
        step(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b0, "R1");

        // R2: empty table passes patterns straight through
        rd_only('0, "R2");
        rd_only('1, "R2");
        for (int k = 0; k < 4; k++) rd_only(rnd_line(), "R2");

        // R3 / R6: every position, one entry, value opposite to raw bit
        for (int p = 0; p < W; p++) begin
            do_reset();
            d = rnd_line();
            fault(p, ~d[p]);
            rd_only(d, "R3");
        end

        // R3: fill entries at boundary positions, read after each
        do_reset();
        fault(0, 1'b1);
        fault(511, 1'b1);
        fault(256, 1'b0);
        rd_only('0, "R3");
        rd_only('1, "R3");
        // R4: later entry overrides an earlier one at the same position
        fault(0, 1'b0);
        rd_only('1, "R4");
        rd_only('0, "R4");
        fault(256, 1'b1);
        rd_only('0, "R4");

        // R5: writes refresh the stored values
        for (int k = 0; k < 4; k++) begin
            step(1'b0, '0, 1'b1, rnd_line(), 1'b0, 0, 1'b0, "R5");
            rd_only(rnd_line(), "R5");
        end
        // R10: read together with a write sees the previous values
        step(1'b1, rnd_line(), 1'b1, rnd_line(), 1'b0, 0, 1'b0, "R10");
        rd_only('0, "R5");

        // R7: write and report together; written bit beats reported value
        d = rnd_line();
        step(1'b1, '1, 1'b1, d, 1'b1, 100, ~d[100], "R10");
        rd_only('0, "R7");
        rd_only('1, "R7");

        // R8: table full; further reports refused, contents kept
        step(1'b1, '0, 1'b0, '0, 1'b1, 7, 1'b1, "R8");
        rd_only('0, "R8");
        rd_only('1, "R8");
        step(1'b0, '0, 1'b1, rnd_line(), 1'b1, 9, 1'b1, "R8");
        rd_only(rnd_line(), "R8");

        // R1 again after a busy table
        do_reset();
        step(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b0, "R1");
        rd_only(rnd_line(), "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule